// File: doc/BRIEF.md
# System Control Port with Address-Line-20 Gate

This block is a one-byte control register on a plain I/O bus. The bus carries an address, a read strobe, a write strobe, a byte of write data and a byte of read data. The register answers at one fixed address and accepts only single-byte accesses. Two of its bits act on the rest of the system. Bit 1 drives the gate for address line 20. A rising transition of bit 0, from one write to the next, makes the block emit a one-cycle request for a system reset. The reset controller that acts on that request sits outside this block.

The block has two reset inputs. The asynchronous, active-low cold reset clears the whole byte. The synchronous device reset clears only bit 0 and keeps every other bit, so a later write that sets bit 0 raises a new request.

The request pulse comes from a two-state machine:
- `REQ_IDLE` moves to `REQ_FIRE` (transition *arm*) when a write at the port address sets bit 0 while the stored bit 0 is 0 and no device reset is present. It stays in `REQ_IDLE` (transition *hold*) otherwise.
- `REQ_FIRE` returns to `REQ_IDLE` (transition *drop*) after one cycle. It would re-arm only if another qualifying write arrived in that cycle.

Top module: `sysctl_port_a20`

## Requirements
- R1: Only address 0x0092 selects the register. A write strobe at any other address leaves the stored byte and both side-effect outputs unchanged.
- R2: A write at the port address stores all 8 bits of the write data. A later read at the port address returns that byte unchanged.
- R3: The read data is 0x00 whenever the read strobe is low or the address is not 0x0092. When selected, it is valid in the same cycle as the strobe.
- R4: The A20 gate output equals bit 1 of the stored byte. It follows a write from the clock edge that accepts that write.
- R5: A write that sets bit 0 while the stored bit 0 is 0 makes the reset request high for exactly the one cycle after the accepting edge.
- R6: A write with bit 0 low, or a write of bit 0 high while the stored bit 0 is already high, raises no reset request.
- R7: After a cold reset the stored byte is 0x00, the A20 gate is low and the reset request is low.
- R8: A device reset clears only bit 0. Bits 7..1 and the A20 gate keep their values, and a later write that sets bit 0 raises a new request.
- R9: When a write and a device reset share a cycle, bits 7..1 take the written value, bit 0 is stored as 0, and no reset request is raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Cold reset, asynchronous, active low |
| dev_rst | input | 1 | Device reset, synchronous, active high |
| io_addr | input | 16 | I/O address |
| io_rd | input | 1 | Read strobe |
| io_wr | input | 1 | Write strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, zero when not selected |
| a20_gate | output | 1 | Address-line-20 gate, bit 1 of the register |
| reset_req | output | 1 | One-cycle system reset request |

## Verification
The bench drives several bit-0 sequences through the port: 0 then 1, 1 then 1, 1 then 0, and 1 with a device reset in the same cycle. These separate a true rising-edge detector from a level detector or a detector that only looks at the data. Writes with bit 1 high and low, and device resets issued while bit 1 is high, show whether the gate follows the stored bit and survives a soft reset. Writes and reads at a neighbouring address and reads with the strobe low show whether the decode is exact. A cold reset in the middle of the run shows that all state is cleared, unlike the device reset.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
    typedef enum logic {
        REQ_IDLE = 1'b0,
        REQ_FIRE = 1'b1
    } req_state_e;
endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode #(
    parameter int unsigned        ADDR_W    = 16,
    parameter logic [ADDR_W-1:0]  PORT_ADDR = 16'h0092
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd_en,
    input  logic              wr_en,
    output logic              rd_hit,
    output logic              wr_hit
);
    logic match;

    always_comb begin
        match  = (addr == PORT_ADDR);
        rd_hit = rd_en && match;
        wr_hit = wr_en && match;
    end
endmodule

// File: rtl/sysctl_store.sv
module sysctl_store #(
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned TRIG_BIT = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dev_rst,
    input  logic              wr_hit,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] q,
    output logic              trig_rise
);
    // A rise counts only when the new bit survives the device reset
    always_comb begin
        trig_rise = wr_hit && wr_data[TRIG_BIT] && !q[TRIG_BIT] && !dev_rst;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            if (wr_hit) begin
                q <= wr_data;
            end
            if (dev_rst) begin
                q[TRIG_BIT] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/sysctl_reqfsm.sv
module sysctl_reqfsm
    import sysctl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    output logic req
);
    req_state_e state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            REQ_IDLE: state_nx = arm ? REQ_FIRE : REQ_IDLE;
            REQ_FIRE: state_nx = arm ? REQ_FIRE : REQ_IDLE;
            default:  state_nx = REQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= REQ_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        unique case (state)
            REQ_FIRE: req = 1'b1;
            default:  req = 1'b0;
        endcase
    end
endmodule

// File: rtl/sysctl_port_a20.sv
module sysctl_port_a20 #(
    parameter int unsigned       ADDR_W    = 16,
    parameter int unsigned       DATA_W    = 8,
    parameter logic [ADDR_W-1:0] PORT_ADDR = 16'h0092,
    parameter int unsigned       GATE_BIT  = 1,
    parameter int unsigned       TRIG_BIT  = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dev_rst,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_rd,
    input  logic              io_wr,
    input  logic [DATA_W-1:0] io_wdata,
    output logic [DATA_W-1:0] io_rdata,
    output logic              a20_gate,
    output logic              reset_req
);
    logic              rd_hit;
    logic              wr_hit;
    logic [DATA_W-1:0] ctl_q;
    logic              trig_rise;

    sysctl_decode #(
        .ADDR_W    (ADDR_W),
        .PORT_ADDR (PORT_ADDR)
    ) u_decode (
        .addr   (io_addr),
        .rd_en  (io_rd),
        .wr_en  (io_wr),
        .rd_hit (rd_hit),
        .wr_hit (wr_hit)
    );

    sysctl_store #(
        .DATA_W   (DATA_W),
        .TRIG_BIT (TRIG_BIT)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .dev_rst   (dev_rst),
        .wr_hit    (wr_hit),
        .wr_data   (io_wdata),
        .q         (ctl_q),
        .trig_rise (trig_rise)
    );

    sysctl_reqfsm u_reqfsm (
        .clk   (clk),
        .rst_n (rst_n),
        .arm   (trig_rise),
        .req   (reset_req)
    );

    always_comb begin
        io_rdata = rd_hit ? ctl_q : '0;
        a20_gate = ctl_q[GATE_BIT];
    end
endmodule

// File: rtl/sysctl_port_a20_chk.sv
module sysctl_port_a20_chk #(
    parameter int unsigned       ADDR_W    = 16,
    parameter int unsigned       DATA_W    = 8,
    parameter logic [ADDR_W-1:0] PORT_ADDR = 16'h0092,
    parameter int unsigned       GATE_BIT  = 1,
    parameter int unsigned       TRIG_BIT  = 0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              dev_rst,
    input logic [ADDR_W-1:0] io_addr,
    input logic              io_rd,
    input logic              io_wr,
    input logic [DATA_W-1:0] io_wdata,
    input logic [DATA_W-1:0] io_rdata,
    input logic              a20_gate,
    input logic              reset_req
);
    logic wr_sel;
    assign wr_sel = io_wr && (io_addr == PORT_ADDR);

    assert_foreign_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_addr != PORT_ADDR) |=> $stable(a20_gate));

    assert_unselected_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_rd && io_addr == PORT_ADDR) |-> io_rdata == '0);

    assert_gate_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_sel |=> a20_gate == $past(io_wdata[GATE_BIT]));

    assert_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |=> !reset_req);

    assert_pulse_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(reset_req) |-> $past(wr_sel && io_wdata[TRIG_BIT] && !dev_rst));

    assert_clear_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sel && !io_wdata[TRIG_BIT]) |=> !reset_req);

    assert_dev_keeps_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_rst && !wr_sel) |=> $stable(a20_gate));

    assert_dev_blocks_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_rst && wr_sel) |=> !reset_req);
endmodule

bind sysctl_port_a20 sysctl_port_a20_chk #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .PORT_ADDR (PORT_ADDR),
    .GATE_BIT  (GATE_BIT),
    .TRIG_BIT  (TRIG_BIT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .dev_rst   (dev_rst),
    .io_addr   (io_addr),
    .io_rd     (io_rd),
    .io_wr     (io_wr),
    .io_wdata  (io_wdata),
    .io_rdata  (io_rdata),
    .a20_gate  (a20_gate),
    .reset_req (reset_req)
);

// File: tb/tb_sysctl_port_a20.sv
`timescale 1ns/1ps
module tb_sysctl_port_a20;
    localparam logic [15:0] PORT = 16'h0092;

    typedef struct {
        int    kind;   // 0 read data, 1 gate, 2 request
        int    exp;
        string rq;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dev_rst = 1'b0;
    logic [15:0] io_addr = '0;
    logic        io_rd = 1'b0;
    logic        io_wr = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic        a20_gate;
    logic        reset_req;

    item_t q[$];
    int    n_checks = 0;
    int    n_fail   = 0;
    logic [7:0] m = '0;
    bit    done = 1'b0;

    always #10 clk = ~clk;

    sysctl_port_a20 dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .dev_rst   (dev_rst),
        .io_addr   (io_addr),
        .io_rd     (io_rd),
        .io_wr     (io_wr),
        .io_wdata  (io_wdata),
        .io_rdata  (io_rdata),
        .a20_gate  (a20_gate),
        .reset_req (reset_req)
    );

    task automatic push(input int kind, input int exp, input string rq);
        item_t it;
        it.kind = kind;
        it.exp  = exp;
        it.rq   = rq;
        q.push_back(it);
    endtask

    // monitor: compares expected items after each falling edge
    initial begin
        forever begin
            @(negedge clk);
            #4;
            while (q.size() > 0) begin
                item_t it;
                int act;
                it = q.pop_front();
                act = (it.kind == 0) ? int'(io_rdata) :
                      (it.kind == 1) ? int'(a20_gate) : int'(reset_req);
                n_checks++;
                if (act != it.exp) begin
                    n_fail++;
                    $display("FAIL %s kind=%0d actual=%0h expected=%0h",
                             it.rq, it.kind, act, it.exp);
                end
            end
        end
    end

    task automatic wr(input logic [15:0] a, input logic [7:0] d,
                      input bit dv, input string rq);
        logic [7:0] nx;
        bit fire;
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1; dev_rst = dv;
        @(posedge clk);
        #1;
        io_wr = 1'b0; dev_rst = 1'b0;
        nx = m;
        if (a == PORT) nx = d;
        if (dv) nx[0] = 1'b0;
        fire = nx[0] && !m[0];
        m = nx;
        push(1, int'(m[1]), rq);
        push(2, int'(fire), rq);
    endtask

    task automatic rd(input logic [15:0] a, input bit en, input string rq);
        @(negedge clk);
        io_addr = a; io_rd = en;
        push(0, (en && a == PORT) ? int'(m) : 0, rq);
        @(posedge clk);
        #1;
        io_rd = 1'b0;
    endtask

    task automatic idle(input string rq);
        @(negedge clk);
        @(posedge clk);
        #1;
        push(2, 0, rq);
    endtask

    task automatic dev_only(input string rq);
        @(negedge clk);
        dev_rst = 1'b1;
        @(posedge clk);
        #1;
        dev_rst = 1'b0;
        m[0] = 1'b0;
        push(1, int'(m[1]), rq);
        push(2, 0, rq);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog all actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R7: state after cold reset
        push(1, 0, "R7"); push(2, 0, "R7");
        rd(PORT, 1'b1, "R7");
        // R2 R4 R6: store byte, gate high, bit0 low gives no request
        wr(PORT, 8'hA6, 1'b0, "R4");
        rd(PORT, 1'b1, "R2");
        // R1: neighbouring address ignored
        wr(16'h0093, 8'hFF, 1'b0, "R1");
        rd(PORT, 1'b1, "R1");
        // R3: unselected reads are zero
        rd(16'h0093, 1'b1, "R3");
        rd(PORT, 1'b0, "R3");
        // R5: bit0 rise gives a one-cycle pulse
        wr(PORT, 8'h07, 1'b0, "R5");
        idle("R5");
        // R6: bit0 held high gives no request
        wr(PORT, 8'h05, 1'b0, "R6");
        wr(PORT, 8'h03, 1'b0, "R6");
        rd(PORT, 1'b1, "R2");
        // R8: device reset clears bit0 only
        dev_only("R8");
        rd(PORT, 1'b1, "R8");
        wr(PORT, 8'h03, 1'b0, "R8");
        idle("R8");
        // R9: write and device reset together
        wr(PORT, 8'hC1, 1'b1, "R9");
        rd(PORT, 1'b1, "R9");
        wr(PORT, 8'h41, 1'b0, "R9");
        idle("R9");
        // R6: bit0 written low again
        wr(PORT, 8'h40, 1'b0, "R6");
        wr(PORT, 8'h5A, 1'b0, "R2");
        rd(PORT, 1'b1, "R2");
        // R7: cold reset mid-run
        @(negedge clk);
        rst_n = 1'b0;
        m = '0;
        @(posedge clk);
        #1;
        push(1, 0, "R7"); push(2, 0, "R7");
        @(negedge clk);
        rst_n = 1'b1;
        rd(PORT, 1'b1, "R7");
        repeat (3) @(posedge clk);
        done = 1'b1;
        summary();
        $finish;
    end
endmodule